// File: doc/BRIEF.md
# Branch-count fetch gating controller

This controller tells the instruction front end, cycle by cycle, whether it should stop fetching. It keeps a running count of conditional branches that have been fetched but not yet resolved. When that count rises above a gating threshold, it asks for a fetch stall. The threshold is not fixed. At the close of every measurement interval, the controller counts how many of the branches resolved in that interval were predicted correctly. It then picks the threshold for the next interval from one of four accuracy bands. Better prediction allows more branches in flight before the gate closes. No per-branch confidence state is kept.

Stalling fetch is not always a good idea, because wrong-path loads often bring in data that the correct path will use later. Two overrides hold the gate open when that is likely. The first is a coarse 5-bit usefulness counter. It counts reported useful wrong-path memory references and is cleared at every interval boundary. The second is a per-branch "predicted useful" hit supplied from outside for the branch being fetched.

Top module: `fetch_gate_ctrl`

## Requirements
- R1: Each cycle with `br_fetch` high and `br_resolve` low raises the in-flight branch count by one. Each cycle with `br_resolve` high and `br_fetch` low lowers it by one, never going below zero. A cycle with both high leaves it unchanged.
- R2: A cycle with `flush` high loads the in-flight count with `flush_survivors`. This takes priority over any fetch or resolve in the same cycle.
- R3: `gate_enable` is high only when the in-flight count is strictly greater than `gate_threshold`, and neither override is active.
- R4: An interval lasts `cfg_interval` cycles and counts from reset. At its last cycle, the resolves in the interval (including that cycle's) are tallied. Call them T, of which C had `br_mispredict` low. The new threshold is:
  - 2 if 100·C < 90·T;
  - otherwise 4 if 100·C < 95·T;
  - otherwise 6 if 100·C < 98·T;
  - otherwise 8.
  The new value appears on `gate_threshold` in the following cycle.
- R5: An interval that ends with no resolves leaves `gate_threshold` unchanged.
- R6: After reset, `gate_threshold` is 8, the in-flight count is 0 and `gate_enable` is low.
- R7: Each cycle with `wp_useful` high raises the usefulness counter by one. While the counter is greater than `cfg_useful_thr`, `gate_enable` is held low.
- R8: The usefulness counter saturates at 31 and does not wrap.
- R9: The usefulness counter returns to 0 at the end of every interval.
- R10: While `pred_useful_hit` is high, `gate_enable` is low in the same cycle. No clock edge is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_fetch | input | 1 | A conditional branch was fetched this cycle |
| br_resolve | input | 1 | A conditional branch resolved this cycle |
| br_mispredict | input | 1 | The resolving branch was mispredicted (qualified by `br_resolve`) |
| flush | input | 1 | Misprediction flush; reload the in-flight count |
| flush_survivors | input | 6 | Number of older unresolved branches that survive the flush |
| wp_useful | input | 1 | A useful wrong-path memory reference was reported |
| pred_useful_hit | input | 1 | The per-branch usefulness predictor hit for the branch being fetched |
| cfg_interval | input | 16 | Interval length in cycles (0 behaves as 1) |
| cfg_useful_thr | input | 5 | Usefulness counter level above which gating is suppressed |
| gate_enable | output | 1 | Request to stall fetch |
| gate_threshold | output | 6 | Current gating threshold |

## Verification
The hardest states to reach from the ports are the accuracy band edges. The ratio of correct to total resolves must land exactly on 90%, 95% or 98% within one interval. Each band scenario therefore resets the block to align the interval counter. It then drives a fixed number of resolves with a chosen number of mispredicts inside one 200-cycle interval, such as 10 with one miss and 20 with one miss. It reads `gate_threshold` after the boundary and again after an empty interval. Saturation of the usefulness counter is seen only through the gate. The bench overdrives the counter and then raises `cfg_useful_thr` to 30, a level at which a wrapped count would reopen the gate.

// File: rtl/fg_pkg.sv
package fg_pkg;

    localparam int USE_W   = 5;
    localparam int USE_MAX = (1 << USE_W) - 1;

    typedef logic [USE_W-1:0] use_cnt_t;

    typedef enum logic [1:0] {
        BAND_POOR = 2'd0,
        BAND_FAIR = 2'd1,
        BAND_GOOD = 2'd2,
        BAND_BEST = 2'd3
    } band_e;

endpackage

// File: rtl/fg_inflight.sv
module fg_inflight #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch,
    input  logic             resolve,
    input  logic             flush,
    input  logic [CNT_W-1:0] survivors,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.cnt = survivors;
        end else if (fetch && !resolve && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (resolve && !fetch && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && fetch && !resolve && st_q.cnt != CNT_MAX) |=> st_q.cnt == $past(st_q.cnt) + 1'b1); // R1
    AST_CNT_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !fetch && st_q.cnt == '0) |=> st_q.cnt == '0); // R1
    AST_FLUSH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> st_q.cnt == $past(survivors)); // R2

endmodule

// File: rtl/fg_thr_tuner.sv
module fg_thr_tuner
    import fg_pkg::*;
#(
    parameter int IVL_W   = 16,
    parameter int CNT_W   = 6,
    parameter int PCT0    = 90,
    parameter int PCT1    = 95,
    parameter int PCT2    = 98,
    parameter int THR0    = 2,
    parameter int THR1    = 4,
    parameter int THR2    = 6,
    parameter int THR3    = 8,
    parameter int THR_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resolve,
    input  logic             mispredict,
    input  logic [IVL_W-1:0] cfg_interval,
    output logic             ivl_end,
    output logic [CNT_W-1:0] threshold
);

    localparam int TAL_W  = IVL_W + 1;
    localparam int ACC_W  = TAL_W + 7;
    localparam int NBANDS = 3;
    localparam int PCT_TAB [NBANDS] = '{PCT0, PCT1, PCT2};

    typedef struct packed {
        logic [IVL_W-1:0] ivl;
        logic [TAL_W-1:0] tot;
        logic [TAL_W-1:0] cor;
        logic [CNT_W-1:0] thr;
    } state_t;

    state_t st_d, st_q;

    logic [TAL_W-1:0]  tot_n, cor_n;
    logic [ACC_W-1:0]  cor_scaled;
    logic [NBANDS-1:0] below;
    band_e             band;
    logic              end_w;

    assign tot_n      = st_q.tot + TAL_W'(resolve);
    assign cor_n      = st_q.cor + TAL_W'(resolve & ~mispredict);
    assign cor_scaled = ACC_W'(cor_n) * ACC_W'(100);
    assign end_w      = (TAL_W'(st_q.ivl) + TAL_W'(1)) >= TAL_W'(cfg_interval);

    for (genvar b = 0; b < NBANDS; b++) begin : g_band
        assign below[b] = cor_scaled < ACC_W'(tot_n) * ACC_W'(PCT_TAB[b]);
    end

    always_comb begin
        if (below[0])      band = BAND_POOR;
        else if (below[1]) band = BAND_FAIR;
        else if (below[2]) band = BAND_GOOD;
        else               band = BAND_BEST;
    end

    function automatic logic [CNT_W-1:0] band_thr(input band_e bsel);
        case (bsel)
            BAND_POOR: band_thr = CNT_W'(THR0);
            BAND_FAIR: band_thr = CNT_W'(THR1);
            BAND_GOOD: band_thr = CNT_W'(THR2);
            default:   band_thr = CNT_W'(THR3);
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (end_w) begin
            st_d.ivl = '0;
            st_d.tot = '0;
            st_d.cor = '0;
            if (tot_n != '0) st_d.thr = band_thr(band);
        end else begin
            st_d.ivl = st_q.ivl + 1'b1;
            st_d.tot = tot_n;
            st_d.cor = cor_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.thr <= CNT_W'(THR_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign ivl_end   = end_w;
    assign threshold = st_q.thr;

    AST_THR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.thr == CNT_W'(THR0) || st_q.thr == CNT_W'(THR1) ||
         st_q.thr == CNT_W'(THR2) || st_q.thr == CNT_W'(THR3) ||
         st_q.thr == CNT_W'(THR_RST))); // R4
    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !end_w |=> $stable(st_q.thr)); // R4
    AST_EMPTY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (end_w && st_q.tot == '0 && !resolve) |=> $stable(st_q.thr)); // R5

endmodule

// File: rtl/fg_useful.sv
module fg_useful
    import fg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     useful,
    input  logic     clear,
    output use_cnt_t count
);

    typedef struct packed {
        use_cnt_t cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (useful && st_q.cnt != use_cnt_t'(USE_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    AST_USE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == use_cnt_t'(USE_MAX) && !clear) |=> st_q.cnt == use_cnt_t'(USE_MAX)); // R8
    AST_USE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> st_q.cnt == '0); // R9
    AST_USE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && useful && st_q.cnt != use_cnt_t'(USE_MAX)) |=> st_q.cnt == $past(st_q.cnt) + 1'b1); // R7

endmodule

// File: rtl/fetch_gate_ctrl.sv
module fetch_gate_ctrl
    import fg_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int IVL_W   = 16,
    parameter int PCT0    = 90,
    parameter int PCT1    = 95,
    parameter int PCT2    = 98,
    parameter int THR0    = 2,
    parameter int THR1    = 4,
    parameter int THR2    = 6,
    parameter int THR3    = 8,
    parameter int THR_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_fetch,
    input  logic             br_resolve,
    input  logic             br_mispredict,
    input  logic             flush,
    input  logic [CNT_W-1:0] flush_survivors,
    input  logic             wp_useful,
    input  logic             pred_useful_hit,
    input  logic [IVL_W-1:0] cfg_interval,
    input  logic [USE_W-1:0] cfg_useful_thr,
    output logic             gate_enable,
    output logic [CNT_W-1:0] gate_threshold
);

    logic [CNT_W-1:0] inflight;
    logic [CNT_W-1:0] thr;
    logic             ivl_end;
    use_cnt_t         use_cnt;
    logic             over_count;
    logic             phase_useful;

    fg_inflight #(.CNT_W(CNT_W)) u_inflight (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch     (br_fetch),
        .resolve   (br_resolve),
        .flush     (flush),
        .survivors (flush_survivors),
        .count     (inflight)
    );

    fg_thr_tuner #(
        .IVL_W(IVL_W), .CNT_W(CNT_W),
        .PCT0(PCT0), .PCT1(PCT1), .PCT2(PCT2),
        .THR0(THR0), .THR1(THR1), .THR2(THR2), .THR3(THR3),
        .THR_RST(THR_RST)
    ) u_tuner (
        .clk          (clk),
        .rst_n        (rst_n),
        .resolve      (br_resolve),
        .mispredict   (br_mispredict),
        .cfg_interval (cfg_interval),
        .ivl_end      (ivl_end),
        .threshold    (thr)
    );

    fg_useful u_useful (
        .clk    (clk),
        .rst_n  (rst_n),
        .useful (wp_useful),
        .clear  (ivl_end),
        .count  (use_cnt)
    );

    assign over_count     = inflight > thr;
    assign phase_useful   = use_cnt > cfg_useful_thr;
    assign gate_enable    = over_count && !phase_useful && !pred_useful_hit;
    assign gate_threshold = thr;

    AST_GATE_NEEDS_EXCESS: assert property (@(posedge clk) disable iff (!rst_n)
        gate_enable |-> inflight > gate_threshold); // R3
    AST_HIT_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        pred_useful_hit |-> !gate_enable); // R10
    AST_PHASE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (use_cnt > cfg_useful_thr) |-> !gate_enable); // R7

endmodule

// File: tb/fetch_gate_ctrl_bench.sv
`timescale 1ns/1ps
module fetch_gate_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       br_fetch, br_resolve, br_mispredict, flush;
    logic [5:0] flush_survivors;
    logic       wp_useful, pred_useful_hit;
    logic [15:0] cfg_interval;
    logic [4:0] cfg_useful_thr;
    logic       gate_enable;
    logic [5:0] gate_threshold;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    fetch_gate_ctrl u_fetch_gate_ctrl (
        .clk(clk), .rst_n(rst_n),
        .br_fetch(br_fetch), .br_resolve(br_resolve), .br_mispredict(br_mispredict),
        .flush(flush), .flush_survivors(flush_survivors),
        .wp_useful(wp_useful), .pred_useful_hit(pred_useful_hit),
        .cfg_interval(cfg_interval), .cfg_useful_thr(cfg_useful_thr),
        .gate_enable(gate_enable), .gate_threshold(gate_threshold)
    );

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        br_fetch = 0; br_resolve = 0; br_mispredict = 0; flush = 0;
        flush_survivors = 0; wp_useful = 0; pred_useful_hit = 0;
    endtask

    task automatic do_reset(input int ivl);
        idle_inputs();
        cfg_interval   = 16'(ivl);
        cfg_useful_thr = 5'd3;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic fetch_n(input int n);
        for (int i = 0; i < n; i++) begin
            br_fetch = 1; tick();
        end
        br_fetch = 0;
    endtask

    task automatic resolve_n(input int n);
        for (int i = 0; i < n; i++) begin
            br_resolve = 1; tick();
        end
        br_resolve = 0;
    endtask

    task automatic test_reset();
        do_reset(1000);
        check("R6 threshold after reset", gate_threshold, 8);
        check("R6 gate after reset", gate_enable, 0);
    endtask

    task automatic test_count();
        do_reset(1000);
        fetch_n(8);
        check("R3 count equal to threshold", gate_enable, 0);
        fetch_n(1);
        check("R3 count above threshold", gate_enable, 1);
        br_fetch = 1; br_resolve = 1; tick(); br_fetch = 0; br_resolve = 0;
        check("R1 fetch with resolve keeps count", gate_enable, 1);
        resolve_n(1);
        check("R1 resolve lowers count", gate_enable, 0);
        resolve_n(12);
        fetch_n(8);
        check("R1 no underflow below zero", gate_enable, 0);
        fetch_n(1);
        check("R1 count rebuilt from zero", gate_enable, 1);
    endtask

    task automatic test_flush();
        do_reset(1000);
        fetch_n(12);
        flush = 1; flush_survivors = 6'd3; tick(); flush = 0;
        check("R2 flush reload low", gate_enable, 0);
        fetch_n(6);
        check("R2 counts on from survivors", gate_enable, 1);
        flush = 1; flush_survivors = 6'd8; br_fetch = 1; tick();
        flush = 0; br_fetch = 0;
        check("R2 flush beats fetch", gate_enable, 0);
        flush = 1; flush_survivors = 6'd10; tick(); flush = 0;
        check("R2 flush reload high", gate_enable, 1);
    endtask

    task automatic acc_case(input int n, input int mis, input int exp, input string tag);
        do_reset(200);
        for (int i = 0; i < n; i++) begin
            br_resolve = 1; br_mispredict = (i < mis); tick();
        end
        br_resolve = 0; br_mispredict = 0;
        repeat (250 - n) tick();
        check(tag, gate_threshold, exp);
    endtask

    task automatic test_bands();
        acc_case(10, 0, 8, "R4 100% accuracy");
        acc_case(20, 1, 6, "R4 95% boundary");
        acc_case(100, 3, 6, "R4 97% accuracy");
        acc_case(100, 6, 4, "R4 94% accuracy");
        acc_case(10, 1, 4, "R4 90% boundary");
        acc_case(10, 2, 2, "R4 80% accuracy");
        repeat (200) tick();
        check("R5 empty interval keeps threshold", gate_threshold, 2);
        fetch_n(3);
        check("R4 low threshold gates early", gate_enable, 1);
    endtask

    task automatic test_useful();
        do_reset(1000);
        fetch_n(9);
        check("R7 gate before useful reports", gate_enable, 1);
        for (int i = 0; i < 3; i++) begin wp_useful = 1; tick(); end
        wp_useful = 0;
        check("R7 counter at threshold still gates", gate_enable, 1);
        wp_useful = 1; tick(); wp_useful = 0;
        check("R7 counter above threshold suppresses", gate_enable, 0);
        for (int i = 0; i < 40; i++) begin wp_useful = 1; tick(); end
        wp_useful = 0;
        cfg_useful_thr = 5'd30; #1;
        check("R8 saturated counter stays above 30", gate_enable, 0);
        repeat (1000) tick();
        check("R9 interval end clears counter", gate_enable, 1);
        cfg_useful_thr = 5'd0; #1;
        check("R9 counter is zero after clear", gate_enable, 1);
    endtask

    task automatic test_hit();
        do_reset(1000);
        fetch_n(10);
        check("R10 gate without hit", gate_enable, 1);
        pred_useful_hit = 1; #1;
        check("R10 hit forces gate low", gate_enable, 0);
        pred_useful_hit = 0; #1;
        check("R10 gate returns after hit", gate_enable, 1);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_count();
        test_flush();
        test_bands();
        test_useful();
        test_hit();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule